// File: doc/BRIEF.md
# DRAM Parallel Test Mode Decoder

This block is the device-side behaviour of a small DRAM array that carries a latched parallel-test mode. It samples the active-low row strobe, column strobe and write enable on every clock and classifies each row-strobe cycle by the order of the strobes when the row strobe falls. A cycle in which write enable and column strobe are both low ahead of the row strobe, and stay low for a qualifying window, sets the test flag. A refresh with write enable high, or a row-strobe cycle during which the column strobe never falls, clears it.

While the flag is set, the top column address bit is ignored. A write lands in both words of the pair that differ only in that bit. A read returns, on each DQ line, a high level when the two stored bits of that line agree and a low level when they differ. This result comes a fixed number of clocks later than normal read data. Outside test mode the array behaves as a plain word store with early-write and read cycles. Timing is expressed in clock counts, and the DQ bus is split into an input, an output and an output enable.

Top module: `dram_ptest`

## Requirements
- R1: After reset `test_mode` is 0 and `dq_oe` is 0.
- R2: Outside test mode, a cycle whose column strobe falls with `we_n` low stores `dq_in` at row `addr[ROW_BITS-1:0]` (latched when the row strobe falls) and column `addr[COL_BITS-1:0]` (latched when the column strobe falls). A cycle whose column strobe falls with `we_n` high drives that word on `dq_out` with `dq_oe` high, starting READ_LAT clock edges after the edge that samples the column strobe low.
- R3: If `cas_n` and `we_n` are both sampled low on at least WE_SETUP edges immediately before the edge that samples `ras_n` falling, and `we_n` is sampled low on each of the WE_HOLD edges after it, `test_mode` becomes 1 on the last of those edges.
- R4: If `we_n` is sampled high during that hold window, the cycle does not enter test mode.
- R5: If the setup window before the row-strobe fall is shorter than WE_SETUP edges, the cycle does not enter test mode.
- R6: Once set, `test_mode` stays 1 through ordinary read and write cycles and through repeated entry cycles.
- R7: In test mode, a write stores `dq_in` into both the column with the top column bit 0 and the column with the top column bit 1, keeping the other column bits as addressed.
- R8: In test mode, a read drives each bit `i` of `dq_out` to 1 when bit `i` of the two paired words is equal and to 0 otherwise. The result appears READ_LAT+TEST_EXTRA edges after the column strobe is sampled low, and `dq_out` holds steady while `dq_oe` stays high.
- R9: A refresh cycle whose column strobe is low and `we_n` is high when the row strobe falls clears `test_mode`.
- R10: A row-strobe cycle during which the column strobe never falls clears `test_mode` on the edge that samples `ras_n` high.
- R11: Outside test mode, a refresh cycle with the column strobe first leaves `test_mode` at 0 and leaves stored data unchanged.
- R12: `dq_oe` is high only after edges that sample `cas_n` low. It drops on the first edge that samples `cas_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Multiplexed row / column address |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data or per-line compare result |
| dq_oe | output | 1 | Output enable for `dq_out` |
| test_mode | output | 1 | Latched parallel-test flag |

## Verification
On every cycle, the embedded properties check four things. The flag only rises after an edge that sampled write enable and the row strobe low. It never drops while the row strobe and write enable are low with the column strobe high. Output enable follows a sampled-low column strobe, and read data holds while output enable stays high. They also check that a test-mode write leaves both words of the pair equal to the written value. The scenarios show what properties cannot. These are the exact edge on which a qualified entry sets the flag, and the rejection of short setup and short hold windows. They also cover the two exit cycles, the pass and fail patterns produced by pair comparison, the extra test-read latency, and read-back of both copies after a test-mode write.

// File: rtl/dram_ptest_pkg.sv
package dram_ptest_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ROW   = 2'd1,
      PH_REFR  = 2'd2,
      PH_ENTRY = 2'd3
   } phase_t;
endpackage

// File: rtl/dram_ptest_strobe.sv
module dram_ptest_strobe
   import dram_ptest_pkg::*;
#(
   parameter int WE_SETUP = 3,
   parameter int WE_HOLD  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output logic row_go,
   output logic col_go,
   output logic test_mode
);
   localparam int SW = $clog2(WE_SETUP + 1) < 1 ? 1 : $clog2(WE_SETUP + 1);
   localparam int HW = $clog2(WE_HOLD + 1) < 1 ? 1 : $clog2(WE_HOLD + 1);

   if (WE_HOLD < 1) begin : g_bad_hold
      $error("WE_HOLD must be at least 1");
   end
   if (WE_SETUP < 0) begin : g_bad_setup
      $error("WE_SETUP must not be negative");
   end

   logic          ras_q, cas_q, cas_seen, test_q;
   logic [SW-1:0] setup_cnt;
   logic [HW-1:0] hold_cnt;
   phase_t        phase;
   logic          ras_fall, ras_rise, cas_fall;

   assign ras_fall  = ras_q & ~ras_n;
   assign ras_rise  = ~ras_q & ras_n;
   assign cas_fall  = cas_q & ~cas_n;
   assign row_go    = ras_fall & cas_n;
   assign col_go    = (phase == PH_ROW) & cas_fall & ~ras_n;
   assign test_mode = test_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q     <= 1'b1;
         cas_q     <= 1'b1;
         cas_seen  <= 1'b0;
         test_q    <= 1'b0;
         setup_cnt <= '0;
         hold_cnt  <= '0;
         phase     <= PH_IDLE;
      end else begin
         ras_q <= ras_n;
         cas_q <= cas_n;
         if (!we_n && !cas_n) begin
            if (setup_cnt != SW'(WE_SETUP))
               setup_cnt <= setup_cnt + 1'b1;
         end else begin
            setup_cnt <= '0;
         end

         if (ras_fall) begin
            if (!cas_n) begin
               if (!we_n && (setup_cnt >= SW'(WE_SETUP))) begin
                  phase    <= PH_ENTRY;
                  hold_cnt <= '0;
               end else begin
                  phase  <= PH_REFR;
                  test_q <= 1'b0;
               end
            end else begin
               phase    <= PH_ROW;
               cas_seen <= 1'b0;
            end
         end else if (ras_rise) begin
            if ((phase == PH_ROW && !cas_seen) || phase == PH_ENTRY)
               test_q <= 1'b0;
            phase <= PH_IDLE;
         end else if (phase == PH_ENTRY) begin
            if (we_n) begin
               test_q <= 1'b0;
               phase  <= PH_REFR;
            end else if (hold_cnt == HW'(WE_HOLD - 1)) begin
               test_q <= 1'b1;
               phase  <= PH_REFR;
            end else begin
               hold_cnt <= hold_cnt + 1'b1;
            end
         end else if (phase == PH_ROW && cas_fall) begin
            cas_seen <= 1'b1;
         end
      end
   end

   // R3: the flag is only raised by an edge that saw write enable and row strobe low
   assert_entry_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_q) |-> $past(!we_n && !ras_n));

   // R6: a write with the row strobe low never drops the flag
   assert_keep_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(test_q) |-> $past(ras_n || we_n || !cas_n));
endmodule

// File: rtl/dram_ptest_cells.sv
module dram_ptest_cells #(
   parameter int DQ_W     = 8,
   parameter int ROW_BITS = 2,
   parameter int COL_BITS = 4,
   parameter int AW       = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            row_go,
   input  logic            col_go,
   input  logic            we_n,
   input  logic            test_mode,
   input  logic [AW-1:0]   addr,
   input  logic [DQ_W-1:0] dq_in,
   output logic [DQ_W-1:0] rd_word
);
   localparam int WORDS = 1 << (ROW_BITS + COL_BITS);
   localparam int PB    = COL_BITS - 1;
   localparam int IW    = ROW_BITS + COL_BITS;

   logic [DQ_W-1:0]     mem [WORDS];
   logic [ROW_BITS-1:0] row_q;
   logic [COL_BITS-1:0] col_q;
   logic [DQ_W-1:0]     lo_w, hi_w, norm_w, eq_w;
   logic [IW-1:0]       wr_lo, wr_hi, wr_one;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
      end else begin
         if (row_go) row_q <= addr[ROW_BITS-1:0];
         if (col_go) col_q <= addr[COL_BITS-1:0];
      end
   end

   assign wr_lo  = {row_q, 1'b0, addr[PB-1:0]};
   assign wr_hi  = {row_q, 1'b1, addr[PB-1:0]};
   assign wr_one = {row_q, addr[COL_BITS-1:0]};

   always_ff @(posedge clk) begin
      if (col_go && !we_n) begin
         if (test_mode) begin
            mem[wr_lo] <= dq_in;
            mem[wr_hi] <= dq_in;
         end else begin
            mem[wr_one] <= dq_in;
         end
      end
   end

   assign lo_w   = mem[{row_q, 1'b0, col_q[PB-1:0]}];
   assign hi_w   = mem[{row_q, 1'b1, col_q[PB-1:0]}];
   assign norm_w = mem[{row_q, col_q}];

   for (genvar i = 0; i < DQ_W; i++) begin : g_cmp
      assign eq_w[i] = ~(lo_w[i] ^ hi_w[i]);
   end

   assign rd_word = test_mode ? eq_w : norm_w;

   // R7: a test-mode write leaves both words of the pair holding the written value
   assert_pair_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (col_go && !we_n && test_mode) |=> (lo_w == $past(dq_in) && hi_w == $past(dq_in)));
endmodule

// File: rtl/dram_ptest_timer.sv
module dram_ptest_timer #(
   parameter int DQ_W       = 8,
   parameter int READ_LAT   = 2,
   parameter int TEST_EXTRA = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            col_go,
   input  logic            we_n,
   input  logic            cas_n,
   input  logic            test_mode,
   input  logic [DQ_W-1:0] rd_word,
   output logic            dq_oe,
   output logic [DQ_W-1:0] dq_out
);
   localparam int MAXL = READ_LAT + TEST_EXTRA;
   localparam int CW   = $clog2(MAXL + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         dq_oe  <= 1'b0;
         dq_out <= '0;
      end else if (col_go) begin
         cnt   <= we_n ? (test_mode ? CW'(MAXL) : CW'(READ_LAT)) : '0;
         dq_oe <= 1'b0;
      end else if (cas_n) begin
         cnt   <= '0;
         dq_oe <= 1'b0;
      end else if (cnt == CW'(1)) begin
         cnt    <= '0;
         dq_oe  <= 1'b1;
         dq_out <= rd_word;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   // R12: output enable only follows a sampled-low column strobe
   assert_oe_cas_R12: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $past(!cas_n));

   // R8: read data holds while the output stays enabled
   assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |-> $stable(dq_out));
endmodule

// File: rtl/dram_ptest.sv
module dram_ptest #(
   parameter int DQ_W       = 8,
   parameter int ROW_BITS   = 2,
   parameter int COL_BITS   = 4,
   parameter int AW         = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS,
   parameter int READ_LAT   = 2,
   parameter int TEST_EXTRA = 2,
   parameter int WE_SETUP   = 3,
   parameter int WE_HOLD    = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ras_n,
   input  logic            cas_n,
   input  logic            we_n,
   input  logic [AW-1:0]   addr,
   input  logic [DQ_W-1:0] dq_in,
   output logic [DQ_W-1:0] dq_out,
   output logic            dq_oe,
   output logic            test_mode
);
   if (AW < ROW_BITS || AW < COL_BITS) begin : g_bad_aw
      $error("AW must cover both row and column bits");
   end
   if (COL_BITS < 2 || ROW_BITS < 1) begin : g_bad_geom
      $error("need COL_BITS >= 2 and ROW_BITS >= 1");
   end
   if (READ_LAT < 1 || TEST_EXTRA < 0) begin : g_bad_lat
      $error("READ_LAT must be at least 1 and TEST_EXTRA non-negative");
   end

   logic            row_go, col_go;
   logic [DQ_W-1:0] rd_word;

   dram_ptest_strobe #(.WE_SETUP(WE_SETUP), .WE_HOLD(WE_HOLD)) u_strobe (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .row_go(row_go), .col_go(col_go), .test_mode(test_mode)
   );

   dram_ptest_cells #(.DQ_W(DQ_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .AW(AW)) u_cells (
      .clk(clk), .rst_n(rst_n), .row_go(row_go), .col_go(col_go), .we_n(we_n),
      .test_mode(test_mode), .addr(addr), .dq_in(dq_in), .rd_word(rd_word)
   );

   dram_ptest_timer #(.DQ_W(DQ_W), .READ_LAT(READ_LAT), .TEST_EXTRA(TEST_EXTRA)) u_timer (
      .clk(clk), .rst_n(rst_n), .col_go(col_go), .we_n(we_n), .cas_n(cas_n),
      .test_mode(test_mode), .rd_word(rd_word), .dq_oe(dq_oe), .dq_out(dq_out)
   );
endmodule

// File: tb/dram_ptest_test.sv
module dram_ptest_test;
   localparam int DQ_W = 8, RB = 2, CB = 4, AW = 4, LAT = 2, EXTRA = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0]   addr = '0;
   logic [DQ_W-1:0] dq_in = '0;
   logic [DQ_W-1:0] dq_out;
   logic            dq_oe, test_mode;

   int total = 0, bad = 0, cyc = 0, cas_drop_cyc = 0;
   bit done = 0, tm_exp = 0, oe_prev = 0;
   logic [DQ_W-1:0] model [1 << (RB + CB)];
   logic [DQ_W-1:0] q_data [$];
   int              q_lat  [$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dram_ptest #(.DQ_W(DQ_W), .ROW_BITS(RB), .COL_BITS(CB), .AW(AW),
                .READ_LAT(LAT), .TEST_EXTRA(EXTRA), .WE_SETUP(3), .WE_HOLD(3)) uut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .test_mode(test_mode)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever the output enable rises
   always @(negedge clk) begin
      if (rst_n && dq_oe && !oe_prev) begin
         if (q_data.size() == 0) begin
            chk("R12 unexpected output", 1, 0);
         end else begin
            chk("R2/R8 read data", int'(dq_out), int'(q_data.pop_front()));
            chk("R2/R8 read latency", cyc - cas_drop_cyc, q_lat.pop_front());
         end
      end
      oe_prev = dq_oe;
   end

   task automatic write_cyc(input int row, input int col, input logic [DQ_W-1:0] d);
      ras_n = 0; addr = AW'(row);
      @(negedge clk);
      addr = AW'(col); we_n = 0; dq_in = d; cas_n = 0;
      repeat (2) @(negedge clk);
      cas_n = 1; we_n = 1;
      @(negedge clk);
      ras_n = 1;
      repeat (2) @(negedge clk);
      if (tm_exp) begin
         model[row * 16 + (col & 7)]     = d;
         model[row * 16 + (col & 7) + 8] = d;
      end else begin
         model[row * 16 + col] = d;
      end
   endtask

   task automatic read_cyc(input int row, input int col);
      logic [DQ_W-1:0] e;
      if (tm_exp) e = ~(model[row * 16 + (col & 7)] ^ model[row * 16 + (col & 7) + 8]);
      else        e = model[row * 16 + col];
      ras_n = 0; addr = AW'(row);
      @(negedge clk);
      addr = AW'(col); cas_n = 0; cas_drop_cyc = cyc;
      q_data.push_back(e);
      q_lat.push_back(tm_exp ? LAT + EXTRA + 1 : LAT + 1);
      repeat (LAT + EXTRA + 2) @(negedge clk);
      cas_n = 1;
      @(negedge clk);
      chk("R12 oe drops after column strobe rises", int'(dq_oe), 0);
      ras_n = 1;
      repeat (2) @(negedge clk);
   endtask

   // setup: edges with we/cas low before row fall; hold: edges after it with we low
   task automatic entry_cyc(input int setup, input int hold);
      we_n = 0; cas_n = 0;
      repeat (setup) @(negedge clk);
      ras_n = 0;
      repeat (hold + 1) @(negedge clk);
      we_n = 1;
      repeat (2) @(negedge clk);
      ras_n = 1; cas_n = 1;
      repeat (2) @(negedge clk);
   endtask

   task automatic cbr_cyc();
      cas_n = 0;
      @(negedge clk);
      ras_n = 0;
      repeat (3) @(negedge clk);
      ras_n = 1; cas_n = 1;
      repeat (2) @(negedge clk);
   endtask

   task automatic ras_only_cyc(input int row);
      ras_n = 0; addr = AW'(row);
      repeat (3) @(negedge clk);
      chk("R10 flag held while row strobe low", int'(test_mode), 1);
      ras_n = 1;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset test_mode", int'(test_mode), 0);
      chk("R1 reset dq_oe", int'(dq_oe), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      write_cyc(1, 3, 8'hA5);
      write_cyc(1, 11, 8'h5A);
      write_cyc(2, 0, 8'h0F);
      write_cyc(2, 8, 8'h0F);
      write_cyc(0, 5, 8'hC3);
      write_cyc(0, 13, 8'hC1);
      read_cyc(1, 3);   // R2
      read_cyc(1, 11);  // R2
      read_cyc(0, 13);  // R2

      cbr_cyc();
      chk("R11 refresh outside test leaves flag", int'(test_mode), 0);
      read_cyc(1, 3);   // R11 data unchanged

      entry_cyc(2, 3);
      chk("R5 short setup rejected", int'(test_mode), 0);
      entry_cyc(3, 2);
      chk("R4 short hold rejected", int'(test_mode), 0);

      // R3: exact edge of entry
      we_n = 0; cas_n = 0;
      repeat (3) @(negedge clk);
      ras_n = 0;
      repeat (3) @(negedge clk);
      chk("R3 flag not yet set before last hold edge", int'(test_mode), 0);
      @(negedge clk);
      chk("R3 flag set on last hold edge", int'(test_mode), 1);
      we_n = 1;
      repeat (2) @(negedge clk);
      ras_n = 1; cas_n = 1;
      repeat (2) @(negedge clk);
      tm_exp = 1;

      read_cyc(2, 0);   // R8 all equal
      read_cyc(0, 5);   // R8 one line differs
      read_cyc(1, 11);  // R8 all differ, top column bit ignored
      chk("R6 flag kept after test reads", int'(test_mode), 1);
      entry_cyc(3, 3);
      chk("R6 flag kept after repeated entry", int'(test_mode), 1);

      write_cyc(3, 2, 8'h3C);  // R7
      chk("R6 flag kept after test write", int'(test_mode), 1);
      read_cyc(3, 10);  // R7 pair now equal
      cbr_cyc();
      tm_exp = 0;
      chk("R9 refresh with write enable high clears", int'(test_mode), 0);
      read_cyc(3, 2);   // R7 low copy
      read_cyc(3, 10);  // R7 high copy

      entry_cyc(3, 3);
      chk("R3 re-entry", int'(test_mode), 1);
      ras_only_cyc(2);
      chk("R10 row-only cycle clears", int'(test_mode), 0);

      repeat (4) @(negedge clk);
      chk("scoreboard drained", q_data.size(), 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule